// File: doc/BRIEF.md
# ATA Single-Sector PIO Transfer Controller

This block moves exactly one sector between a host and an ATA disk in PIO mode. It drives a register access port that is held until acknowledged, and it runs a fixed sequence. First it polls the status register until the drive is idle and ready. Then it loads the task file, issues a read or write command, and waits for the drive to request data. It then moves the sector's words. After a write it waits for the drive to finish.

The host gives the address in one of two forms. The first is cylinder/head/sector with a 1-based sector where 256 is encoded as 00h. The second is a 28-bit logical block address. The host also gives a device-select bit and the direction. Sector words leave on a valid/ready output stream for reads and arrive on a valid/ready input stream for writes.

A result code and, for device failures, the drive's error byte report the outcome. Each polling loop gives up after a configurable number of status reads. A badly formed cylinder/head/sector request is refused before any bus activity.

Top module: `ata_sector_ctrl`

## Requirements
- R1: A CHS request whose sector is 0 or above 256, whose head is above 15, or whose cylinder is above 1023 ends with result 3 (rejected). `done` is high in the cycle after the start edge, and there is no bus access. LBA requests are never rejected.
- R2: Before any register write, status (address 7) is read repeatedly until bit 7 (BSY) is 0 and bit 6 (RDY) is 1.
- R3: The task file is written in address order 2, 3, 4, 5, 6, then the command at address 7. Address 2 always receives 01h.
- R4: In CHS mode the bytes are as follows. Address 3 gets sector[7:0], so 256 becomes 00h. Address 4 gets cylinder[7:0]. Address 5 gets {6'b0, cylinder[9:8]}. Address 6 gets {3'b101, dev, head[3:0]}.
- R5: In LBA mode address 3 gets lba[7:0], address 4 gets lba[15:8] and address 5 gets lba[23:16]. Address 6 gets {3'b111, dev, lba[27:24]}.
- R6: The command byte is 20h for a read and 30h for a write.
- R7: After the command, status is polled. BSY set means keep polling. Otherwise ERR (bit 0) takes the error path before DRQ (bit 3) is considered. DRQ with BSY clear starts the transfer.
- R8: Exactly WORDS 16-bit words pass through address 0, in order. Read words appear on `rd_data` and are held with `rd_valid` until `rd_ready`. Write words are taken when `wr_valid` and `wr_ready` are both high.
- R9: After the last write word, status is polled until BSY is clear. ERR then selects the error path; otherwise the result is 0 (ok). A read finishes with result 0 once its last word is accepted.
- R10: On the error path, address 1 is read once, its low byte appears on `err_byte`, and the result is 1 (device error).
- R11: After POLL_LIMIT status reads in one loop without meeting its exit condition, the operation ends with result 2 (timeout). No further bus access follows.
- R12: `done` is a one-cycle pulse. `result` and `err_byte` hold until the next completion. `busy` is high from the start edge until `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| op_write | input | 1 | 1 = write sector, 0 = read sector |
| op_lba | input | 1 | 1 = LBA addressing, 0 = CHS |
| dev_sel | input | 1 | Device select bit for the head/device byte |
| chs_cyl | input | 16 | CHS cylinder (valid 0..1023) |
| chs_head | input | 8 | CHS head (valid 0..15) |
| chs_sect | input | 9 | CHS sector (valid 1..256) |
| lba | input | 28 | Logical block address |
| wr_data | input | 16 | Write stream word |
| wr_valid | input | 1 | Write stream valid |
| wr_ready | output | 1 | Write stream ready |
| rd_data | output | 16 | Read stream word |
| rd_valid | output | 1 | Read stream valid |
| rd_ready | input | 1 | Read stream ready |
| bus_req | output | 1 | Register access request, held until acknowledged |
| bus_we | output | 1 | 1 = register write |
| bus_addr | output | 3 | Register address |
| bus_wdata | output | 16 | Register write data |
| bus_ack | input | 1 | Access complete (one cycle) |
| bus_rdata | input | 16 | Register read data, valid with `bus_ack` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse |
| result | output | 2 | 0 ok, 1 device error, 2 timeout, 3 rejected |
| err_byte | output | 8 | Error register value on device error |

## Verification
A rejected request must raise `done` in the very first cycle after the start edge. The bench checks that cycle exactly and confirms that the bus access counter did not move.

Every other result depends on the drive model's reply latency. Each register access takes two cycles there: request seen, then acknowledge. The bench therefore waits for the `done` pulse at falling edges. It then compares the model's logged register writes, its status-read count, the stream word counts and the outputs at that falling edge. One cycle later it checks that `done` has dropped and `result` has held.

Stream handshakes and the model's replies live in bench flops on the rising edge. Captured words are thus always the values present before the edge.

// File: rtl/ata_pkg.sv
package ata_pkg;
    localparam int DW = 16;

    typedef enum logic [1:0] {
        RES_OK  = 2'd0,
        RES_DEV = 2'd1,
        RES_TMO = 2'd2,
        RES_BAD = 2'd3
    } res_t;

    typedef enum logic [2:0] {
        S_IDLE, S_RDY, S_LOAD, S_DRQ, S_XFER, S_BUSYW, S_ERRR, S_DONE
    } state_t;

    localparam logic [7:0] CMD_RD = 8'h20;
    localparam logic [7:0] CMD_WR = 8'h30;

    localparam int ST_BSY = 7;
    localparam int ST_RDY = 6;
    localparam int ST_DRQ = 3;
    localparam int ST_ERR = 0;

    localparam logic [2:0] A_DATA = 3'd0;
    localparam logic [2:0] A_ERR  = 3'd1;
    localparam logic [2:0] A_SCNT = 3'd2;
    localparam logic [2:0] A_STAT = 3'd7;
    localparam logic [2:0] LAST_STEP = 3'd5;

    typedef struct packed {
        logic [7:0] scnt;
        logic [7:0] snum;
        logic [7:0] cyl_lo;
        logic [7:0] cyl_hi;
        logic [7:0] devhd;
    } tf_t;

    function automatic logic [7:0] tf_pick(tf_t tf, logic [2:0] step, logic is_wr);
        case (step)
            3'd0:    tf_pick = tf.scnt;
            3'd1:    tf_pick = tf.snum;
            3'd2:    tf_pick = tf.cyl_lo;
            3'd3:    tf_pick = tf.cyl_hi;
            3'd4:    tf_pick = tf.devhd;
            default: tf_pick = is_wr ? CMD_WR : CMD_RD;
        endcase
    endfunction
endpackage

// File: rtl/ata_taskfile.sv
module ata_taskfile
    import ata_pkg::*;
(
    input  logic        op_lba,
    input  logic        dev_sel,
    input  logic [15:0] chs_cyl,
    input  logic [7:0]  chs_head,
    input  logic [8:0]  chs_sect,
    input  logic [27:0] lba,
    output tf_t         tf,
    output logic        tf_ok
);
    logic chs_ok;

    always_comb begin
        chs_ok = (chs_sect != 9'd0) && (chs_sect <= 9'd256) &&
                 (chs_head <= 8'd15) && (chs_cyl <= 16'd1023);
        tf_ok  = op_lba || chs_ok;
        tf.scnt = 8'h01;
        if (op_lba) begin
            tf.snum   = lba[7:0];
            tf.cyl_lo = lba[15:8];
            tf.cyl_hi = lba[23:16];
            tf.devhd  = {3'b111, dev_sel, lba[27:24]};
        end else begin
            tf.snum   = chs_sect[7:0];
            tf.cyl_lo = chs_cyl[7:0];
            tf.cyl_hi = {6'b0, chs_cyl[9:8]};
            tf.devhd  = {3'b101, dev_sel, chs_head[3:0]};
        end
    end
endmodule

// File: rtl/ata_poll_timer.sv
module ata_poll_timer #(
    parameter int LIMIT = 100000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic fail,
    output logic last
);
    localparam int CW = $clog2(LIMIT + 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else if (fail)  cnt <= cnt + 1'b1;
    end

    assign last = (cnt == CW'(LIMIT - 1));

    // R11: the loop never counts past its final allowed miss
    a_r11_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt < CW'(LIMIT));
endmodule

// File: rtl/ata_xfer_ctrl.sv
module ata_xfer_ctrl
    import ata_pkg::*;
#(
    parameter int WORDS = 256
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          op_write,
    input  tf_t           tf_in,
    input  logic          tf_ok,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_valid,
    output logic          wr_ready,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid,
    input  logic          rd_ready,
    output logic          bus_req,
    output logic          bus_we,
    output logic [2:0]    bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic          bus_ack,
    input  logic [DW-1:0] bus_rdata,
    output logic          poll_clr,
    output logic          poll_fail,
    input  logic          poll_last,
    output logic          busy,
    output logic          done,
    output logic [1:0]    result,
    output logic [7:0]    err_byte
);
    localparam int WCW = $clog2(WORDS + 1);

    state_t         state;
    logic [2:0]     step;
    logic [WCW-1:0] wcnt;
    tf_t            tf_q;
    logic           is_wr_q;
    res_t           res_q;
    logic [7:0]     err_q;
    logic           cnt_full;
    logic           poll_st;
    logic           exit_ok;
    logic           poll_miss;
    logic [7:0]     st;

    assign st       = bus_rdata[7:0];
    assign cnt_full = (wcnt == WCW'(WORDS));
    assign poll_st  = (state == S_RDY) || (state == S_DRQ) || (state == S_BUSYW);

    always_comb begin
        case (state)
            S_RDY:   exit_ok = !st[ST_BSY] && st[ST_RDY];
            S_DRQ:   exit_ok = !st[ST_BSY] && (st[ST_ERR] || st[ST_DRQ]);
            default: exit_ok = !st[ST_BSY];
        endcase
    end

    assign poll_miss = poll_st && bus_ack && !exit_ok;
    assign poll_fail = poll_miss && !poll_last;
    assign poll_clr  = !poll_st;

    always_comb begin
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = A_STAT;
        bus_wdata = '0;
        case (state)
            S_RDY, S_DRQ, S_BUSYW: bus_req = 1'b1;
            S_LOAD: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = A_SCNT + step;
                bus_wdata = {8'h00, tf_pick(tf_q, step, is_wr_q)};
            end
            S_XFER: begin
                bus_addr = A_DATA;
                if (is_wr_q) begin
                    bus_req   = wr_valid && !cnt_full;
                    bus_we    = 1'b1;
                    bus_wdata = wr_data;
                end else begin
                    bus_req = !rd_valid && !cnt_full;
                end
            end
            S_ERRR: begin
                bus_req  = 1'b1;
                bus_addr = A_ERR;
            end
            default: ;
        endcase
    end

    assign wr_ready = (state == S_XFER) && is_wr_q && bus_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            step     <= '0;
            wcnt     <= '0;
            tf_q     <= '0;
            is_wr_q  <= 1'b0;
            res_q    <= RES_OK;
            err_q    <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else if (poll_miss && poll_last) begin
            res_q <= RES_TMO;
            state <= S_DONE;
        end else begin
            case (state)
                S_IDLE: if (start) begin
                    tf_q    <= tf_in;
                    is_wr_q <= op_write;
                    err_q   <= '0;
                    if (tf_ok) state <= S_RDY;
                    else begin
                        res_q <= RES_BAD;
                        state <= S_DONE;
                    end
                end
                S_RDY: if (bus_ack && exit_ok) begin
                    step  <= '0;
                    state <= S_LOAD;
                end
                S_LOAD: if (bus_ack) begin
                    if (step == LAST_STEP) state <= S_DRQ;
                    else step <= step + 3'd1;
                end
                S_DRQ: if (bus_ack && exit_ok) begin
                    if (st[ST_ERR]) state <= S_ERRR;
                    else begin
                        wcnt  <= '0;
                        state <= S_XFER;
                    end
                end
                S_XFER: begin
                    if (is_wr_q) begin
                        if (bus_ack) begin
                            wcnt <= wcnt + 1'b1;
                            if (wcnt == WCW'(WORDS - 1)) state <= S_BUSYW;
                        end
                    end else if (bus_ack) begin
                        rd_data  <= bus_rdata;
                        rd_valid <= 1'b1;
                        wcnt     <= wcnt + 1'b1;
                    end else if (rd_valid && rd_ready) begin
                        rd_valid <= 1'b0;
                        if (cnt_full) begin
                            res_q <= RES_OK;
                            state <= S_DONE;
                        end
                    end
                end
                S_BUSYW: if (bus_ack && exit_ok) begin
                    if (st[ST_ERR]) state <= S_ERRR;
                    else begin
                        res_q <= RES_OK;
                        state <= S_DONE;
                    end
                end
                S_ERRR: if (bus_ack) begin
                    err_q <= bus_rdata[7:0];
                    res_q <= RES_DEV;
                    state <= S_DONE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign done     = (state == S_DONE);
    assign busy     = (state != S_IDLE);
    assign result   = res_q;
    assign err_byte = err_q;

    // R1: a malformed request finishes at once with no bus request
    a_r1_reject_quiet: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE && start && !tf_ok) |=> (done && !bus_req && result == RES_BAD));
    // R3: a pending access keeps its address and direction
    a_r3_req_hold: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));
    // R5: head/device byte always carries the fixed outer bits
    a_r5_devhd_frame: assert property (@(posedge clk) disable iff (rst)
        (state == S_LOAD) |-> (tf_q.devhd[7] && tf_q.devhd[5]));
    // R8: a presented read word stays until accepted
    a_r8_rd_hold: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
    // R8: never more than WORDS data accesses
    a_r8_word_bound: assert property (@(posedge clk) disable iff (rst)
        wcnt <= WCW'(WORDS));
    // R11: timeout ends the operation with no further access
    a_r11_timeout_ends: assert property (@(posedge clk) disable iff (rst)
        (poll_miss && poll_last) |=> (done && !bus_req && result == RES_TMO));
    // R12: completion is a single-cycle pulse
    a_r12_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: rtl/ata_sector_ctrl.sv
module ata_sector_ctrl
    import ata_pkg::*;
#(
    parameter int WORDS      = 256,
    parameter int POLL_LIMIT = 100000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        op_write,
    input  logic        op_lba,
    input  logic        dev_sel,
    input  logic [15:0] chs_cyl,
    input  logic [7:0]  chs_head,
    input  logic [8:0]  chs_sect,
    input  logic [27:0] lba,
    input  logic [15:0] wr_data,
    input  logic        wr_valid,
    output logic        wr_ready,
    output logic [15:0] rd_data,
    output logic        rd_valid,
    input  logic        rd_ready,
    output logic        bus_req,
    output logic        bus_we,
    output logic [2:0]  bus_addr,
    output logic [15:0] bus_wdata,
    input  logic        bus_ack,
    input  logic [15:0] bus_rdata,
    output logic        busy,
    output logic        done,
    output logic [1:0]  result,
    output logic [7:0]  err_byte
);
    tf_t  tf;
    logic tf_ok;
    logic poll_clr, poll_fail, poll_last;

    ata_taskfile u_tf (
        .op_lba  (op_lba),
        .dev_sel (dev_sel),
        .chs_cyl (chs_cyl),
        .chs_head(chs_head),
        .chs_sect(chs_sect),
        .lba     (lba),
        .tf      (tf),
        .tf_ok   (tf_ok)
    );

    ata_poll_timer #(.LIMIT(POLL_LIMIT)) u_timer (
        .clk (clk),
        .rst (rst),
        .clr (poll_clr),
        .fail(poll_fail),
        .last(poll_last)
    );

    ata_xfer_ctrl #(.WORDS(WORDS)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .op_write (op_write),
        .tf_in    (tf),
        .tf_ok    (tf_ok),
        .wr_data  (wr_data),
        .wr_valid (wr_valid),
        .wr_ready (wr_ready),
        .rd_data  (rd_data),
        .rd_valid (rd_valid),
        .rd_ready (rd_ready),
        .bus_req  (bus_req),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_ack  (bus_ack),
        .bus_rdata(bus_rdata),
        .poll_clr (poll_clr),
        .poll_fail(poll_fail),
        .poll_last(poll_last),
        .busy     (busy),
        .done     (done),
        .result   (result),
        .err_byte (err_byte)
    );
endmodule

// File: tb/ata_sector_ctrl_bench.sv
`timescale 1ns/1ps
module ata_sector_ctrl_bench;
    localparam int WORDS = 16;
    localparam int PL    = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic        start = 0, op_write = 0, op_lba = 0, dev_sel = 0;
    logic [15:0] chs_cyl = 0;
    logic [7:0]  chs_head = 0;
    logic [8:0]  chs_sect = 1;
    logic [27:0] lba = 0;
    logic [15:0] wr_data;
    logic        wr_valid, wr_ready;
    logic [15:0] rd_data;
    logic        rd_valid, rd_ready;
    logic        bus_req, bus_we, bus_ack;
    logic [2:0]  bus_addr;
    logic [15:0] bus_wdata, bus_rdata;
    logic        busy, done;
    logic [1:0]  result;
    logic [7:0]  err_byte;

    ata_sector_ctrl #(.WORDS(WORDS), .POLL_LIMIT(PL)) u_ata_sector_ctrl (
        .clk(clk), .rst(rst), .start(start), .op_write(op_write), .op_lba(op_lba),
        .dev_sel(dev_sel), .chs_cyl(chs_cyl), .chs_head(chs_head), .chs_sect(chs_sect),
        .lba(lba), .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata), .busy(busy), .done(done),
        .result(result), .err_byte(err_byte)
    );

    // scenario knobs, written only by the main process
    int          sc_pre = 0, sc_post = 0, sc_post2 = 0, sc_errat = 0;
    bit          sc_never = 0, sc_wr_en = 0;
    logic [7:0]  sc_errv = 0;
    logic [15:0] sc_seed = 0;

    function automatic logic [15:0] pat(int i, logic [15:0] seed);
        return (16'(i) * 16'h0101) ^ seed;
    endfunction

    // bench cycle counter for stream pacing
    int cyc = 0;
    always_ff @(posedge clk) cyc <= cyc + 1;

    // drive model
    int         phase, busy_left, nwr, ndata, nrd, nstat, bus_cnt, wbad;
    bit         rdy_given, seq_ok, viol;
    logic [7:0] tfw [0:7];
    always_ff @(posedge clk) begin
        if (rst) begin
            bus_ack <= 0; bus_rdata <= 0; bus_cnt <= 0;
            phase <= 0; busy_left <= 0; nwr <= 0; ndata <= 0; nrd <= 0;
            nstat <= 0; wbad <= 0; rdy_given <= 0; seq_ok <= 1; viol <= 0;
        end else if (start) begin
            bus_ack <= 0; phase <= 0; busy_left <= sc_pre; nwr <= 0; ndata <= 0;
            nrd <= 0; nstat <= 0; wbad <= 0; rdy_given <= 0; seq_ok <= 1; viol <= 0;
            for (int k = 0; k < 8; k++) tfw[k] <= 8'hxx;
        end else if (bus_req && !bus_ack) begin
            bus_ack <= 1;
            bus_cnt <= bus_cnt + 1;
            if (bus_we) begin
                if (bus_addr == 3'd0) begin
                    if (bus_wdata != pat(ndata, sc_seed)) wbad <= wbad + 1;
                    ndata <= ndata + 1;
                    if (ndata == WORDS - 1) begin phase <= 2; busy_left <= sc_post2; end
                end else begin
                    tfw[bus_addr] <= bus_wdata[7:0];
                    if (int'(bus_addr) != nwr + 2) seq_ok <= 0;
                    if (!rdy_given) viol <= 1;
                    nwr <= nwr + 1;
                    if (bus_addr == 3'd7) begin phase <= 1; busy_left <= sc_post; end
                end
            end else begin
                case (bus_addr)
                    3'd7: begin
                        nstat <= nstat + 1;
                        if (busy_left > 0) busy_left <= busy_left - 1;
                        if (phase == 0) begin
                            if (sc_never) bus_rdata <= 16'h0080;
                            else if (busy_left > 0) bus_rdata <= busy_left[0] ? 16'h0080 : 16'h0000;
                            else begin bus_rdata <= 16'h0050; rdy_given <= 1; end
                        end else if (phase == 1) begin
                            if (busy_left > 0) bus_rdata <= 16'h0088;
                            else if (sc_errat == 1) bus_rdata <= 16'h0049;
                            else bus_rdata <= 16'h0058;
                        end else begin
                            if (busy_left > 0) bus_rdata <= 16'h0080;
                            else if (sc_errat == 2) bus_rdata <= 16'h0051;
                            else bus_rdata <= 16'h0050;
                        end
                    end
                    3'd1: bus_rdata <= {8'h00, sc_errv};
                    3'd0: begin bus_rdata <= pat(nrd, sc_seed); nrd <= nrd + 1; end
                    default: bus_rdata <= 16'h0000;
                endcase
            end
        end else begin
            bus_ack <= 0;
        end
    end

    // read stream sink
    int rd_idx, rbad;
    always_ff @(posedge clk) begin
        if (rst || start) begin
            rd_idx <= 0; rbad <= 0; rd_ready <= 0;
        end else begin
            rd_ready <= (cyc % 3) != 0;
            if (rd_valid && rd_ready) begin
                if (rd_data != pat(rd_idx, sc_seed)) rbad <= rbad + 1;
                rd_idx <= rd_idx + 1;
            end
        end
    end

    // write stream source
    int wr_idx;
    assign wr_data = pat(wr_idx, sc_seed);
    always_ff @(posedge clk) begin
        if (rst || start) begin
            wr_idx <= 0; wr_valid <= 0;
        end else begin
            if (wr_valid && wr_ready) wr_idx <= wr_idx + 1;
            if (!wr_valid || wr_ready) wr_valid <= sc_wr_en && ((cyc % 4) != 1);
        end
    end

    int nchk = 0, nerr = 0;
    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // expected task file byte for address a (2..7)
    function automatic logic [7:0] exp_tf(int a, bit wr, bit l, bit d, logic [15:0] c,
                                          logic [7:0] h, logic [8:0] s, logic [27:0] lv);
        case (a)
            2: return 8'h01;
            3: return l ? lv[7:0] : s[7:0];
            4: return l ? lv[15:8] : c[7:0];
            5: return l ? lv[23:16] : {6'b0, c[9:8]};
            6: return l ? {3'b111, d, lv[27:24]} : {3'b101, d, h[3:0]};
            default: return wr ? 8'h30 : 8'h20;
        endcase
    endfunction

    task automatic run_op(input bit wr, input bit l, input bit d, input logic [15:0] c,
                          input logic [7:0] h, input logic [8:0] s, input logic [27:0] lv,
                          input int pre, input int post, input int post2, input int errat,
                          input bit never, input logic [7:0] errv, input logic [1:0] exp_res,
                          input int exp_nstat);
        int wait_c;
        int cnt0;
        sc_pre = pre; sc_post = post; sc_post2 = post2; sc_errat = errat;
        sc_never = never; sc_errv = errv; sc_seed = sc_seed + 16'h1357; sc_wr_en = wr;
        @(negedge clk);
        cnt0 = bus_cnt;
        op_write = wr; op_lba = l; dev_sel = d; chs_cyl = c; chs_head = h;
        chs_sect = s; lba = lv; start = 1;
        @(negedge clk);
        start = 0;
        wait_c = 0;
        while (!done && wait_c < 5000) begin @(negedge clk); wait_c++; end
        if (!done) begin
            chk(0, "watchdog done never seen", 0, 1);
            return;
        end
        chk(result == exp_res, "R1 R7 R9 R10 R11 result code", result, exp_res);
        if (exp_res == 2'd3) begin
            chk(wait_c == 0 && bus_cnt == cnt0, "R1 reject immediate and no bus access",
                bus_cnt - cnt0, 0);
        end else begin
            chk(!viol, "R2 write before ready status", viol, 0);
            if (exp_nstat >= 0) chk(nstat == exp_nstat, "R11 status read count", nstat, exp_nstat);
            if (!(exp_res == 2'd2 && nwr == 0)) begin
                chk(seq_ok && nwr == 6, "R3 task file write order", nwr, 6);
                for (int a = 2; a <= 7; a++)
                    chk(tfw[a] == exp_tf(a, wr, l, d, c, h, s, lv),
                        a == 7 ? "R6 command byte" : (l ? "R5 LBA packing" : "R4 CHS packing"),
                        tfw[a], exp_tf(a, wr, l, d, c, h, s, lv));
            end
            if (exp_res == 2'd0) begin
                if (wr) chk(ndata == WORDS && wbad == 0, "R8 write words", ndata, WORDS);
                else    chk(rd_idx == WORDS && rbad == 0 && nrd == WORDS, "R8 read words", rd_idx, WORDS);
            end
            if (exp_res == 2'd1) chk(err_byte == errv, "R10 error byte", err_byte, errv);
        end
        @(negedge clk);
        chk(!done && !busy && result == exp_res, "R12 done pulse and held result",
            {done, busy, result}, {2'b00, exp_res});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(!busy && !done && !bus_req && !rd_valid, "R12 reset state",
            {busy, done, bus_req, rd_valid}, 0);

        // R1 rejects
        run_op(0, 0, 0, 16'd5, 8'd2, 9'd0,   0, 0, 0, 0, 0, 0, 0, 2'd3, -1);
        run_op(0, 0, 0, 16'd5, 8'd2, 9'd257, 0, 0, 0, 0, 0, 0, 0, 2'd3, -1);
        run_op(1, 0, 1, 16'd5, 8'd16, 9'd3,  0, 0, 0, 0, 0, 0, 0, 2'd3, -1);
        run_op(0, 0, 0, 16'd1024, 8'd0, 9'd3, 0, 0, 0, 0, 0, 0, 0, 2'd3, -1);

        // CHS sweep over boundary values (R4 R6 R8 R9)
        begin
            int k;
            logic [15:0] cyls [5];
            logic [7:0]  heads [3];
            logic [8:0]  secs [3];
            cyls = '{16'd0, 16'd1, 16'd255, 16'd256, 16'd1023};
            heads = '{8'd0, 8'd7, 8'd15};
            secs = '{9'd1, 9'd255, 9'd256};
            k = 0;
            foreach (cyls[i]) foreach (heads[j]) foreach (secs[m]) begin
                run_op(k[0], 0, k[1], cyls[i], heads[j], secs[m], 0,
                       k % 3, k % 2, k % 3, 0, 0, 0, 2'd0, -1);
                k++;
            end
        end

        // LBA sweep (R5)
        begin
            logic [27:0] lv [6];
            lv = '{28'h0, 28'h1, 28'h0ABCDEF, 28'hFFFFFFF, 28'h1234567, 28'h8000100};
            foreach (lv[i]) begin
                run_op(i % 2, 1, (i / 2) % 2, 16'hFFFF, 8'hFF, 9'd0, lv[i],
                       1, 2, 1, 0, 0, 0, 2'd0, -1);
            end
        end

        // R7 ERR precedence over DRQ after command, R10 error register
        run_op(0, 0, 0, 16'd10, 8'd3, 9'd9, 0, 2, 3, 0, 1, 0, 8'h04, 2'd1, 3 + 4);
        // R9 error after write completion
        run_op(1, 1, 1, 0, 0, 0, 28'h0123456, 0, 0, 2, 2, 0, 8'h40, 2'd1, 1 + 1 + 3);
        // R9 write ok after busy completion
        run_op(1, 0, 0, 16'd77, 8'd1, 9'd2, 0, 0, 0, 5, 0, 0, 0, 2'd0, 1 + 1 + 6);
        // R11 timeout while waiting for ready
        run_op(0, 0, 0, 16'd1, 8'd1, 9'd1, 0, 0, 0, 0, 0, 1, 0, 2'd2, PL);
        // R11 timeout while waiting for DRQ
        run_op(0, 1, 0, 0, 0, 0, 28'h55, 1, 20, 0, 0, 0, 0, 2'd2, 2 + PL);
        // R11 timeout while waiting for write completion
        run_op(1, 0, 1, 16'd3, 8'd4, 9'd5, 0, 0, 0, 30, 0, 0, 0, 2'd2, 1 + 1 + PL);
        // R11 exact limit: PL-1 misses still succeeds
        run_op(0, 0, 0, 16'd2, 8'd2, 9'd2, 0, PL - 1, 0, 0, 0, 0, 0, 2'd0, PL + 1);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule